// File: doc/BRIEF.md
# Exception Entry Sequencer

This block performs the entry half of exception and interrupt handling for a small 32-bit processor core. Four request sources reach it: a maskable hardware interrupt carrying a vector from the interrupt controller, a non-maskable interrupt, a software break carrying a trap vector, and a bus fault carrying a fault vector. Alongside the requests it sees the live program counter, stack pointer, status word, delay-slot amount, exception base address and kernel stack pointer.

When a request is acceptable, the block snapshots that state, selects one source by fixed priority and computes the new return address, exception status word, shifted status word and stack pointers. It then reads the handler address from a table in memory through a request/acknowledge read port. The core applies the results when the one-cycle `done` strobe appears. Requests that arrive while an entry is in progress are not sampled, and the core keeps them pending.

Top module: `exc_entry_seq`

## Requirements
- R1: The read address is `base + vector*4`, and `new_pc` equals the read data returned with `mem_ack`. `done` is high for exactly one cycle, the cycle after the acknowledged read.
- R2: A non-maskable interrupt uses vector 0, copies the PC into `nmi_ret` (`nmi_ret_wr`=1, `ret_wr`=0) and clears the M flag (status bit 9) before the status shift of R7.
- R3: A bus fault, a break and a hardware interrupt use `fault_vec`, `trap_vec` and `irq_vec` respectively, and write the return address to `ret_pc` (`ret_wr`=1, `nmi_ret_wr`=0).
- R4: `exs` holds the low 8 bits of the chosen vector in bits 15:8, and all its other bits are zero.
- R5: For non-NMI entries, `ret_pc` = PC − `cur_dslot`. `dslot_clr` pulses together with `done` whenever the sampled `cur_dslot` was non-zero.
- R6: If the user flag (status bit 8) was set at entry: `usp_new` = old SP, `sp_new` = `ksp` and `usp_wr`=1. Otherwise `sp_new` = old SP and `usp_wr`=0.
- R7: `ccs_new` = {old bits 31:30, old bits 19:0, ten zero bits}, where the old value is taken after the R2 M clear.
- R8: A hardware interrupt is accepted only when status bit 6 (I) is set and `irq_locked` is low. A non-maskable interrupt is accepted only when M (bit 9) is set. An unaccepted request produces neither `mem_req` nor `done`.
- R9: When several requests are acceptable, the priority is bus fault, then break, then non-maskable interrupt, then hardware interrupt.
- R10: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. Input changes after acceptance do not affect the results of the entry in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Maskable hardware interrupt pending |
| irq_vec | input | 8 | Vector from the interrupt controller |
| nmi_req | input | 1 | Non-maskable interrupt pending |
| brk_req | input | 1 | Software break pending |
| trap_vec | input | 8 | Break vector |
| bf_req | input | 1 | Bus fault pending |
| fault_vec | input | 8 | Bus fault vector |
| irq_locked | input | 1 | Hardware interrupts locked out |
| cur_pc | input | 32 | Current program counter |
| cur_sp | input | 32 | Current stack pointer |
| cur_ccs | input | 32 | Current status word |
| cur_dslot | input | 2 | Delay-slot amount, 0 outside a slot |
| exc_base | input | 32 | Handler table base address |
| ksp | input | 32 | Kernel stack pointer |
| mem_req | output | 1 | Handler table read request |
| mem_addr | output | 32 | Handler table read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle strobe: all results valid |
| new_pc | output | 32 | Handler address |
| ret_pc | output | 32 | Exception return address |
| ret_wr | output | 1 | ret_pc is to be written |
| nmi_ret | output | 32 | NMI return address |
| nmi_ret_wr | output | 1 | nmi_ret is to be written |
| exs | output | 32 | Exception status word |
| ccs_new | output | 32 | Shifted status word |
| sp_new | output | 32 | New stack pointer |
| usp_new | output | 32 | Saved user stack pointer |
| usp_wr | output | 1 | usp_new is to be written |
| dslot_clr | output | 1 | Clear the delay-slot state (with done) |

## Verification
An accepted request is captured on the first clock edge, and the derived registers are loaded on the next edge. `mem_req` rises after that second edge. `done` rises on the edge that sees `mem_ack`, and the bench samples `done` and every result on the following falling edge. While `mem_req` is high, the bench checks the address once and acknowledges after a random delay of 0 to 3 cycles. For an ignored request it watches `mem_req` and `done` for eight falling edges. It scrambles the non-request inputs during an entry, so any result taken late from the live inputs would show up as a mismatch.

// File: rtl/exc_pkg.sv
package exc_pkg;
   typedef enum logic [2:0] {
      EK_NONE,
      EK_IRQ,
      EK_NMI,
      EK_BRK,
      EK_BF
   } exc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_UPDATE,
      ST_FETCH,
      ST_DONE
   } exc_state_e;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
   import exc_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int VEC_W = 8,
   parameter int I_BIT = 6,
   parameter int M_BIT = 9
) (
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             nmi_req,
   input  logic             brk_req,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic             bf_req,
   input  logic [VEC_W-1:0] fault_vec,
   input  logic             irq_locked,
   input  logic [XLEN-1:0]  ccs,
   output exc_kind_e        kind,
   output logic [VEC_W-1:0] vec
);
   logic irq_ok, nmi_ok;

   assign irq_ok = irq_req && ccs[I_BIT] && !irq_locked;
   assign nmi_ok = nmi_req && ccs[M_BIT];

   // fixed priority: fault, break, nmi, irq
   always_comb begin
      kind = EK_NONE;
      vec  = '0;
      if (bf_req) begin
         kind = EK_BF;
         vec  = fault_vec;
      end else if (brk_req) begin
         kind = EK_BRK;
         vec  = trap_vec;
      end else if (nmi_ok) begin
         kind = EK_NMI;
         vec  = '0;
      end else if (irq_ok) begin
         kind = EK_IRQ;
         vec  = irq_vec;
      end
   end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
   import exc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VEC_W     = 8,
   parameter int DS_W      = 2,
   parameter int U_BIT     = 8,
   parameter int M_BIT     = 9,
   parameter bit REWIND_EN = 1'b1
) (
   input  exc_kind_e        kind,
   input  logic [VEC_W-1:0] vec,
   input  logic [XLEN-1:0]  pc,
   input  logic [XLEN-1:0]  sp,
   input  logic [XLEN-1:0]  ccs,
   input  logic [DS_W-1:0]  dslot,
   input  logic [XLEN-1:0]  ksp,
   output logic [XLEN-1:0]  ret_pc,
   output logic             ret_wr,
   output logic [XLEN-1:0]  nmi_ret,
   output logic             nmi_ret_wr,
   output logic [XLEN-1:0]  exs,
   output logic [XLEN-1:0]  ccs_new,
   output logic [XLEN-1:0]  sp_new,
   output logic [XLEN-1:0]  usp_new,
   output logic             usp_wr
);
   localparam int KEEP_LO = 30;
   localparam int SHIFT   = 10;

   logic [XLEN-1:0] ccs_pre, rewound, vec_ext;
   logic            is_nmi, user;

   assign is_nmi  = (kind == EK_NMI);
   assign user    = ccs[U_BIT];
   assign vec_ext = XLEN'(vec);

   generate
      if (REWIND_EN) begin : g_rewind
         assign rewound = pc - XLEN'(dslot);
      end else begin : g_norewind
         assign rewound = pc;
      end
   endgenerate

   always_comb begin
      ccs_pre = ccs;
      if (is_nmi) ccs_pre[M_BIT] = 1'b0;
   end

   assign ccs_new    = {ccs_pre[XLEN-1:KEEP_LO], ccs_pre[KEEP_LO-SHIFT-1:0], {SHIFT{1'b0}}};
   assign ret_pc     = rewound;
   assign ret_wr     = !is_nmi;
   assign nmi_ret    = pc;
   assign nmi_ret_wr = is_nmi;
   assign exs        = (vec_ext & XLEN'(255)) << 8;
   assign sp_new     = user ? ksp : sp;
   assign usp_new    = sp;
   assign usp_wr     = user;
endmodule

// File: rtl/exc_fsm.sv
module exc_fsm
   import exc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic mem_ack,
   output logic cap_en,
   output logic upd_en,
   output logic pc_en,
   output logic mem_req,
   output logic done
);
   exc_state_e state, nxt;

   always_comb begin
      nxt = state;
      case (state)
         ST_IDLE:   if (start) nxt = ST_UPDATE;
         ST_UPDATE: nxt = ST_FETCH;
         ST_FETCH:  if (mem_ack) nxt = ST_DONE;
         default:   nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= nxt;
   end

   assign cap_en  = (state == ST_IDLE) && start;
   assign upd_en  = (state == ST_UPDATE);
   assign mem_req = (state == ST_FETCH);
   assign pc_en   = mem_req && mem_ack;
   assign done    = (state == ST_DONE);

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> mem_req);
   // R1
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R1
   done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(mem_ack));
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
   import exc_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int VEC_W     = 8,
   parameter int DS_W      = 2,
   parameter int U_BIT     = 8,
   parameter int I_BIT     = 6,
   parameter int M_BIT     = 9,
   parameter bit REWIND_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_req,
   input  logic [VEC_W-1:0] irq_vec,
   input  logic             nmi_req,
   input  logic             brk_req,
   input  logic [VEC_W-1:0] trap_vec,
   input  logic             bf_req,
   input  logic [VEC_W-1:0] fault_vec,
   input  logic             irq_locked,
   input  logic [XLEN-1:0]  cur_pc,
   input  logic [XLEN-1:0]  cur_sp,
   input  logic [XLEN-1:0]  cur_ccs,
   input  logic [DS_W-1:0]  cur_dslot,
   input  logic [XLEN-1:0]  exc_base,
   input  logic [XLEN-1:0]  ksp,
   output logic             mem_req,
   output logic [XLEN-1:0]  mem_addr,
   input  logic             mem_ack,
   input  logic [XLEN-1:0]  mem_rdata,
   output logic             done,
   output logic [XLEN-1:0]  new_pc,
   output logic [XLEN-1:0]  ret_pc,
   output logic             ret_wr,
   output logic [XLEN-1:0]  nmi_ret,
   output logic             nmi_ret_wr,
   output logic [XLEN-1:0]  exs,
   output logic [XLEN-1:0]  ccs_new,
   output logic [XLEN-1:0]  sp_new,
   output logic [XLEN-1:0]  usp_new,
   output logic             usp_wr,
   output logic             dslot_clr
);
   localparam int FLAG_FIELD = 10;
   localparam int PAD_W      = XLEN - VEC_W - 2;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("exc_entry_seq: status shift is defined for XLEN of 32");
      end
      if (VEC_W < 1 || VEC_W > 8) begin : g_bad_vec
         $error("exc_entry_seq: VEC_W must be 1..8");
      end
      if (U_BIT >= FLAG_FIELD || I_BIT >= FLAG_FIELD || M_BIT >= FLAG_FIELD) begin : g_bad_flag
         $error("exc_entry_seq: flags must sit in the low ten bits");
      end
      if (U_BIT == I_BIT || U_BIT == M_BIT || I_BIT == M_BIT) begin : g_dup_flag
         $error("exc_entry_seq: flag positions must differ");
      end
   endgenerate

   exc_kind_e        sel_kind, kind_q;
   logic [VEC_W-1:0] sel_vec, vec_q;
   logic [XLEN-1:0]  pc_q, sp_q, ccs_q, base_q, ksp_q;
   logic [DS_W-1:0]  ds_q;
   logic             cap_en, upd_en, pc_en;

   logic [XLEN-1:0]  c_ret, c_nret, c_exs, c_ccs, c_sp, c_usp;
   logic             c_ret_wr, c_nret_wr, c_usp_wr;

   exc_arbiter #(
      .XLEN (XLEN), .VEC_W(VEC_W), .I_BIT(I_BIT), .M_BIT(M_BIT)
   ) u_arb (
      .irq_req   (irq_req),
      .irq_vec   (irq_vec),
      .nmi_req   (nmi_req),
      .brk_req   (brk_req),
      .trap_vec  (trap_vec),
      .bf_req    (bf_req),
      .fault_vec (fault_vec),
      .irq_locked(irq_locked),
      .ccs       (cur_ccs),
      .kind      (sel_kind),
      .vec       (sel_vec)
   );

   exc_fsm u_fsm (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (sel_kind != EK_NONE),
      .mem_ack(mem_ack),
      .cap_en (cap_en),
      .upd_en (upd_en),
      .pc_en  (pc_en),
      .mem_req(mem_req),
      .done   (done)
   );

   exc_state_calc #(
      .XLEN(XLEN), .VEC_W(VEC_W), .DS_W(DS_W),
      .U_BIT(U_BIT), .M_BIT(M_BIT), .REWIND_EN(REWIND_EN)
   ) u_calc (
      .kind      (kind_q),
      .vec       (vec_q),
      .pc        (pc_q),
      .sp        (sp_q),
      .ccs       (ccs_q),
      .dslot     (ds_q),
      .ksp       (ksp_q),
      .ret_pc    (c_ret),
      .ret_wr    (c_ret_wr),
      .nmi_ret   (c_nret),
      .nmi_ret_wr(c_nret_wr),
      .exs       (c_exs),
      .ccs_new   (c_ccs),
      .sp_new    (c_sp),
      .usp_new   (c_usp),
      .usp_wr    (c_usp_wr)
   );

   // snapshot of the request and the core state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q <= EK_NONE;
         vec_q  <= '0;
         pc_q   <= '0;
         sp_q   <= '0;
         ccs_q  <= '0;
         base_q <= '0;
         ksp_q  <= '0;
         ds_q   <= '0;
      end else if (cap_en) begin
         kind_q <= sel_kind;
         vec_q  <= sel_vec;
         pc_q   <= cur_pc;
         sp_q   <= cur_sp;
         ccs_q  <= cur_ccs;
         base_q <= exc_base;
         ksp_q  <= ksp;
         ds_q   <= cur_dslot;
      end
   end

   // derived results
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ret_pc     <= '0;
         ret_wr     <= 1'b0;
         nmi_ret    <= '0;
         nmi_ret_wr <= 1'b0;
         exs        <= '0;
         ccs_new    <= '0;
         sp_new     <= '0;
         usp_new    <= '0;
         usp_wr     <= 1'b0;
      end else if (upd_en) begin
         ret_pc     <= c_ret;
         ret_wr     <= c_ret_wr;
         nmi_ret    <= c_nret;
         nmi_ret_wr <= c_nret_wr;
         exs        <= c_exs;
         ccs_new    <= c_ccs;
         sp_new     <= c_sp;
         usp_new    <= c_usp;
         usp_wr     <= c_usp_wr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     new_pc <= '0;
      else if (pc_en) new_pc <= mem_rdata;
   end

   assign mem_addr  = base_q + {{PAD_W{1'b0}}, vec_q, 2'b00};
   assign dslot_clr = done && (ds_q != '0);

   // R10
   addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_addr));
   // R3
   one_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($countones({ret_wr, nmi_ret_wr}) == 1));
   // R5
   dslot_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dslot_clr |-> done);
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        irq_req = 0, nmi_req = 0, brk_req = 0, bf_req = 0, irq_locked = 0;
   logic [7:0]  irq_vec = 0, trap_vec = 0, fault_vec = 0;
   logic [31:0] cur_pc = 0, cur_sp = 0, cur_ccs = 0, exc_base = 0, ksp = 0;
   logic [1:0]  cur_dslot = 0;
   logic        mem_req, mem_ack = 0, done, ret_wr, nmi_ret_wr, usp_wr, dslot_clr;
   logic [31:0] mem_addr, mem_rdata = 0, new_pc, ret_pc, nmi_ret, exs, ccs_new, sp_new, usp_new;

   int errors = 0;
   int checks = 0;

   always #4 clk = ~clk;

   exc_entry_seq uut (
      .clk(clk), .rst_n(rst_n),
      .irq_req(irq_req), .irq_vec(irq_vec), .nmi_req(nmi_req),
      .brk_req(brk_req), .trap_vec(trap_vec), .bf_req(bf_req),
      .fault_vec(fault_vec), .irq_locked(irq_locked),
      .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_ccs(cur_ccs),
      .cur_dslot(cur_dslot), .exc_base(exc_base), .ksp(ksp),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .done(done), .new_pc(new_pc),
      .ret_pc(ret_pc), .ret_wr(ret_wr), .nmi_ret(nmi_ret),
      .nmi_ret_wr(nmi_ret_wr), .exs(exs), .ccs_new(ccs_new),
      .sp_new(sp_new), .usp_new(usp_new), .usp_wr(usp_wr),
      .dslot_clr(dslot_clr)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] table_data(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
   endfunction

   function automatic logic [31:0] shift_ccs(input logic [31:0] c);
      return {c[31:30], c[19:0], 10'b0};
   endfunction

   task automatic run_case(input bit ir, input bit nm, input bit bk, input bit bf,
                           input logic [7:0] iv, input logic [7:0] tv, input logic [7:0] fv,
                           input logic [31:0] pc, input logic [31:0] sp, input logic [31:0] ccs,
                           input logic [1:0] ds, input logic [31:0] base, input logic [31:0] ks,
                           input bit lk);
      int          kind;
      logic [7:0]  v;
      logic [31:0] ea, cpre;
      int          dly;
      bit          seen;
      bit          got;
      // expected selection: 0 none, 1 irq, 2 nmi, 3 brk, 4 bf (R9)
      kind = 0; v = 0;
      if (bf)                          begin kind = 4; v = fv; end
      else if (bk)                     begin kind = 3; v = tv; end
      else if (nm && ccs[9])           begin kind = 2; v = 0;  end
      else if (ir && ccs[6] && !lk)    begin kind = 1; v = iv; end
      ea = base + {22'b0, v, 2'b00};

      @(negedge clk);
      irq_req = ir; nmi_req = nm; brk_req = bk; bf_req = bf;
      irq_vec = iv; trap_vec = tv; fault_vec = fv;
      cur_pc = pc; cur_sp = sp; cur_ccs = ccs; cur_dslot = ds;
      exc_base = base; ksp = ks; irq_locked = lk;

      if (kind == 0) begin
         got = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_req || done) got = 1;
         end
         chk(!got, "R8 ignored request", {31'b0, got}, 32'h0);
         irq_req = 0; nmi_req = 0; brk_req = 0; bf_req = 0;
         return;
      end

      dly = $urandom_range(0, 3);
      seen = 0;
      got = 0;
      for (int c = 0; c < 60; c++) begin
         @(negedge clk);
         mem_ack = 0;
         if (done) begin got = 1; break; end
         // scramble non-request inputs after acceptance (R10)
         cur_pc = $urandom; cur_sp = $urandom; cur_ccs = $urandom;
         exc_base = $urandom; ksp = $urandom; cur_dslot = 2'($urandom);
         irq_vec = 8'($urandom); trap_vec = 8'($urandom); fault_vec = 8'($urandom);
         if (mem_req) begin
            if (!seen) chk(mem_addr == ea, "R1 table address", mem_addr, ea);
            seen = 1;
            if (dly == 0) begin
               mem_ack = 1;
               mem_rdata = table_data(ea);
            end else dly--;
         end
      end
      chk(got, "R1 watchdog done", {31'b0, got}, 32'h1);
      irq_req = 0; nmi_req = 0; brk_req = 0; bf_req = 0;
      if (!got) return;

      chk(new_pc == table_data(ea), "R1 new_pc", new_pc, table_data(ea));
      chk(exs == {16'b0, v, 8'b0}, "R4 exs", exs, {16'b0, v, 8'b0});
      cpre = ccs;
      if (kind == 2) begin
         cpre[9] = 1'b0;
         chk(nmi_ret_wr && !ret_wr, "R2 nmi return select", {30'b0, nmi_ret_wr, ret_wr}, 32'h2);
         chk(nmi_ret == pc, "R2 nmi_ret", nmi_ret, pc);
      end else begin
         chk(ret_wr && !nmi_ret_wr, "R3 return select", {30'b0, nmi_ret_wr, ret_wr}, 32'h1);
         chk(ret_pc == pc - {30'b0, ds}, "R5 ret_pc rewind", ret_pc, pc - {30'b0, ds});
      end
      chk(dslot_clr == (ds != 0), "R5 dslot_clr", {31'b0, dslot_clr}, {31'b0, ds != 0});
      chk(ccs_new == shift_ccs(cpre), "R7 ccs_new", ccs_new, shift_ccs(cpre));
      if (ccs[8]) begin
         chk(usp_wr && usp_new == sp, "R6 usp save", usp_new, sp);
         chk(sp_new == ks, "R6 sp from ksp", sp_new, ks);
      end else begin
         chk(!usp_wr, "R6 no usp write", {31'b0, usp_wr}, 32'h0);
         chk(sp_new == sp, "R6 sp kept", sp_new, sp);
      end
      @(negedge clk);
      chk(!done, "R1 done single cycle", {31'b0, done}, 32'h0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!mem_req && !done, "R1 reset idle", {30'b0, mem_req, done}, 32'h0);
      chk(new_pc == 0 && exs == 0, "R4 reset outputs", exs, 32'h0);
      rst_n = 1;
      @(negedge clk);

      // R8: hardware interrupt with I clear, or locked
      run_case(1,0,0,0, 8'h21,0,0, 32'h1000, 32'h2000, 32'h0000_0000, 0, 32'h8000, 32'h9000, 0);
      run_case(1,0,0,0, 8'h21,0,0, 32'h1000, 32'h2000, 32'h0000_0040, 0, 32'h8000, 32'h9000, 1);
      // R8: NMI with M clear ignored, NMI with M clear but irq ok -> irq
      run_case(0,1,0,0, 0,0,0, 32'h1000, 32'h2000, 32'h0000_0040, 0, 32'h8000, 32'h9000, 0);
      run_case(1,1,0,0, 8'h33,0,0, 32'h1004, 32'h2000, 32'h0000_0040, 0, 32'h8000, 32'h9000, 0);
      // R9: NMI beats irq; R2 M cleared before shift
      run_case(1,1,0,0, 8'h33,0,0, 32'h1008, 32'h2000, 32'h0000_0340, 0, 32'h8000, 32'h9000, 0);
      // R9: bus fault beats break beats everything
      run_case(1,1,1,1, 8'h33,8'h44,8'h55, 32'h100C, 32'h2000, 32'hC000_0340, 2, 32'h8000, 32'h9000, 0);
      run_case(1,1,1,0, 8'h33,8'h44,8'h55, 32'h1010, 32'h2000, 32'h4000_0340, 1, 32'h8000, 32'h9000, 0);
      // R6 user mode, R4 vector FF, R1 address wrap
      run_case(0,0,1,0, 0,8'hFF,0, 32'h0000_0002, 32'hABCD_0000, 32'hFFFF_FFFF, 3, 32'hFFFF_FF00, 32'h1234_5678, 0);

      for (int n = 0; n < 300; n++) begin
         run_case(1'($urandom), 1'($urandom), 1'($urandom_range(0,3) == 0), 1'($urandom_range(0,5) == 0),
                  8'($urandom), 8'($urandom), 8'($urandom),
                  $urandom, $urandom, $urandom, 2'($urandom),
                  $urandom, $urandom, 1'($urandom_range(0,3) == 0));
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL R1 watchdog expired actual=%h expected=%h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule